// File: doc/BRIEF.md
# Transmit Echo Guard with Failsafe Transmission Timer

This block watches the words a bus terminal puts on the wire. Each word handed to the encoder is held as the expected echo, and the word the receiver decodes back off the bus is compared against it. A differing echo, a missing echo, or a new encoder word arriving before the previous one was echoed counts as a wrap failure. A wrap failure sets a sticky flag that software clears with a read-clear strobe, and it raises a one-cycle interrupt pulse when the interrupt enable is set.

A second function guards each transmit channel against a transmitter that never stops. Each channel has a timer that accumulates microseconds while that channel's transmit-active input is high. When the accumulated time reaches the failsafe ceiling (800 µs by default), the channel's trip output goes high and its transmit permit goes low. Both stay that way until the next command strobe re-arms every channel. One microsecond tick, derived from the system clock by a prescaler, serves both the echo wait window and the failsafe timers. The prescaler also restarts on each command strobe.

Top module: `txEchoGuard`

## Requirements
- R1: When the echo strobe arrives while a word is pending and the echo equals that word in all WORD_W bits, wrapFail stays low and wrapIrq stays low.
- R2: When the echo strobe arrives while a word is pending and the echo differs from it in any bit, wrapFail is high on the cycle after the echo strobe.
- R3: wrapIrq is a pulse one cycle long, high on the same cycle that a new wrap failure sets wrapFail, and only if intEnable was high when the failure was detected. With intEnable low the failure still sets wrapFail.
- R4: wrapFail stays high until a cycle with statusRead high clears it. If a new failure and statusRead fall in the same cycle, wrapFail stays high.
- R5: Two cases count as a wrap failure. One is no echo strobe arriving within ECHO_WAIT_US microsecond ticks after the encoder strobe. The other is a second encoder strobe arriving while the first word is still pending. In the second case the new word becomes the pending word.
- R6: An echo strobe while no word is pending has no effect on wrapFail or wrapIrq.
- R7: Once channel c's transmit-active input has been high for FAILSAFE_US microsecond ticks since the last command strobe, failsafeTrip[c] goes high and txPermit[c] goes low. Both hold until the next command strobe.
- R8: A channel's timer does not advance while its transmit-active input is low. Active time accumulates across gaps.
- R9: A newCmd pulse clears every channel's timer and trip on the next cycle, and txPermit returns high. Each channel counts only its own transmit-active input.
- R10: After reset, wrapFail, wrapIrq and failsafeTrip are all low and txPermit is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encWord | input | WORD_W | Word handed to the encoder |
| encStrobe | input | 1 | encWord valid; arms the echo compare |
| echoWord | input | WORD_W | Word decoded back from the bus |
| echoStrobe | input | 1 | echoWord valid |
| txActive | input | NUM_CH | Transmitter active, one bit per channel |
| newCmd | input | 1 | New command received; re-arms failsafe timers |
| intEnable | input | 1 | Enables the wrap-fail interrupt pulse |
| statusRead | input | 1 | Read-clear of the wrap-fail flag |
| wrapFail | output | 1 | Sticky wrap-fail flag |
| wrapIrq | output | 1 | One-cycle wrap-fail interrupt pulse |
| failsafeTrip | output | NUM_CH | Per-channel transmission timeout |
| txPermit | output | NUM_CH | Per-channel transmit permit, low while tripped |

## Verification
A wrong echo state shows up at wrapFail within one cycle of the echo strobe when the pending word or the armed flag is wrong. When the wait counter is wrong, it shows up within one wait window, as a missed or a false late-echo failure. A failsafe timer that counts while idle, or misses ticks, moves the failsafeTrip edge by whole microseconds. The bench brackets that edge with checks on both sides. A stuck trip shows as txPermit staying low one cycle after newCmd.

// File: rtl/txEchoGuardPkg.sv
package txEchoGuardPkg;
  typedef struct packed {
    logic armWord;
    logic idleWait;
  } echoCtl_t;

  typedef struct packed {
    logic echoEq;
    logic waitDone;
  } echoStat_t;
endpackage

// File: rtl/fsTimerChan.sv
module fsTimerChan #(
  parameter int FAILSAFE_US = 800
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic newCmd,
  input  logic txActive,
  output logic trip
);
  localparam int CW = $clog2(FAILSAFE_US + 1);
  localparam logic [CW-1:0] LAST = CW'(FAILSAFE_US - 1);

  logic [CW-1:0] usCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      usCount <= '0;
      trip    <= 1'b0;
    end else if (newCmd) begin
      usCount <= '0;
      trip    <= 1'b0;
    end else if (txActive && tick && !trip) begin
      usCount <= usCount + 1'b1;
      if (usCount == LAST) trip <= 1'b1;
    end
  end

  AST_TRIP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    newCmd |=> !trip); // R9
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    trip && !newCmd |=> trip); // R7
  AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !txActive && !newCmd |=> $stable(usCount)); // R8
  AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    usCount <= CW'(FAILSAFE_US)); // R7
endmodule

// File: rtl/txEchoDatapath.sv
module txEchoDatapath
  import txEchoGuardPkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int NUM_CH       = 2,
  parameter int CLK_PER_US   = 250,
  parameter int ECHO_WAIT_US = 24,
  parameter int FAILSAFE_US  = 800
) (
  input  logic              clk,
  input  logic              rstN,
  input  echoCtl_t          ctl,
  output echoStat_t         stat,
  input  logic [WORD_W-1:0] encWord,
  input  logic [WORD_W-1:0] echoWord,
  input  logic              newCmd,
  input  logic [NUM_CH-1:0] txActive,
  output logic [NUM_CH-1:0] failsafeTrip,
  output logic [NUM_CH-1:0] txPermit
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int WW = $clog2(ECHO_WAIT_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [WW-1:0] WAIT_END = WW'(ECHO_WAIT_US);

  logic [PW-1:0]     preCount;
  logic              usTick;
  logic [WORD_W-1:0] pendWord;
  logic [WW-1:0]     waitCount;

  // microsecond prescaler, realigned by every command
  assign usTick = (preCount == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 preCount <= '0;
    else if (newCmd || usTick) preCount <= '0;
    else                       preCount <= preCount + 1'b1;
  end

  // expected echo and its wait window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord  <= '0;
      waitCount <= '0;
    end else if (ctl.armWord) begin
      pendWord  <= encWord;
      waitCount <= '0;
    end else if (usTick && !ctl.idleWait && !stat.waitDone) begin
      waitCount <= waitCount + 1'b1;
    end
  end

  assign stat.echoEq   = (echoWord == pendWord);
  assign stat.waitDone = (waitCount == WAIT_END);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChan
    fsTimerChan #(.FAILSAFE_US(FAILSAFE_US)) uTimer (
      .clk      (clk),
      .rstN     (rstN),
      .tick     (usTick),
      .newCmd   (newCmd),
      .txActive (txActive[ch]),
      .trip     (failsafeTrip[ch])
    );
    assign txPermit[ch] = !failsafeTrip[ch];
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    waitCount <= WAIT_END); // R5
  AST_ARM_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.armWord |=> waitCount == '0); // R5
endmodule

// File: rtl/txEchoControl.sv
module txEchoControl
  import txEchoGuardPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      encStrobe,
  input  logic      echoStrobe,
  input  logic      intEnable,
  input  logic      statusRead,
  input  echoStat_t stat,
  output echoCtl_t  ctl,
  output logic      wrapFail,
  output logic      wrapIrq
);
  logic armed;
  logic echoSeen, badEcho, lateEcho, lostEcho, mismatch;

  assign echoSeen = armed && echoStrobe;
  assign badEcho  = echoSeen && !stat.echoEq;
  assign lateEcho = armed && !echoStrobe && stat.waitDone;
  assign lostEcho = armed && !echoStrobe && !stat.waitDone && encStrobe;
  assign mismatch = badEcho || lateEcho || lostEcho;

  assign ctl.armWord  = encStrobe;
  assign ctl.idleWait = !armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     armed <= 1'b0;
    else if (encStrobe)            armed <= 1'b1;
    else if (echoSeen || lateEcho) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrapFail <= 1'b0;
      wrapIrq  <= 1'b0;
    end else begin
      wrapIrq <= mismatch && intEnable;
      if (mismatch)        wrapFail <= 1'b1;
      else if (statusRead) wrapFail <= 1'b0;
    end
  end

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    wrapIrq |-> wrapFail); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    wrapIrq |-> $past(intEnable)); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wrapFail && !statusRead |=> wrapFail); // R4
  AST_IDLE_ECHO_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !armed && !wrapFail |=> !wrapFail); // R6
  AST_ENC_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    encStrobe |=> armed); // R5
endmodule

// File: rtl/txEchoGuard.sv
module txEchoGuard
  import txEchoGuardPkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int NUM_CH       = 2,
  parameter int CLK_PER_US   = 250,
  parameter int ECHO_WAIT_US = 24,
  parameter int FAILSAFE_US  = 800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] encWord,
  input  logic              encStrobe,
  input  logic [WORD_W-1:0] echoWord,
  input  logic              echoStrobe,
  input  logic [NUM_CH-1:0] txActive,
  input  logic              newCmd,
  input  logic              intEnable,
  input  logic              statusRead,
  output logic              wrapFail,
  output logic              wrapIrq,
  output logic [NUM_CH-1:0] failsafeTrip,
  output logic [NUM_CH-1:0] txPermit
);
  echoCtl_t  ctl;
  echoStat_t stat;

  txEchoControl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .encStrobe  (encStrobe),
    .echoStrobe (echoStrobe),
    .intEnable  (intEnable),
    .statusRead (statusRead),
    .stat       (stat),
    .ctl        (ctl),
    .wrapFail   (wrapFail),
    .wrapIrq    (wrapIrq)
  );

  txEchoDatapath #(
    .WORD_W       (WORD_W),
    .NUM_CH       (NUM_CH),
    .CLK_PER_US   (CLK_PER_US),
    .ECHO_WAIT_US (ECHO_WAIT_US),
    .FAILSAFE_US  (FAILSAFE_US)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .stat         (stat),
    .encWord      (encWord),
    .echoWord     (echoWord),
    .newCmd       (newCmd),
    .txActive     (txActive),
    .failsafeTrip (failsafeTrip),
    .txPermit     (txPermit)
  );
endmodule

// File: tb/txEchoGuard_test.sv
`timescale 1ns/1ps
module txEchoGuard_test;
  localparam int CPU  = 4;
  localparam int WAIT = 6;
  localparam int FS   = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] encWord = '0, echoWord = '0;
  logic encStrobe = 1'b0, echoStrobe = 1'b0;
  logic [1:0] txActive = '0;
  logic newCmd = 1'b0, intEnable = 1'b0, statusRead = 1'b0;
  logic wrapFail, wrapIrq;
  logic [1:0] failsafeTrip, txPermit;

  int nTests = 0, nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  txEchoGuard #(
    .WORD_W(16), .NUM_CH(2), .CLK_PER_US(CPU),
    .ECHO_WAIT_US(WAIT), .FAILSAFE_US(FS)
  ) uut (
    .clk(clk), .rstN(rstN), .encWord(encWord), .encStrobe(encStrobe),
    .echoWord(echoWord), .echoStrobe(echoStrobe), .txActive(txActive),
    .newCmd(newCmd), .intEnable(intEnable), .statusRead(statusRead),
    .wrapFail(wrapFail), .wrapIrq(wrapIrq),
    .failsafeTrip(failsafeTrip), .txPermit(txPermit)
  );

  // encWord, echoWord, intEnable, expected wrapFail, expected wrapIrq
  localparam logic [34:0] VEC [7] = '{
    {16'hA5A5, 16'hA5A5, 1'b1, 1'b0, 1'b0},
    {16'h1234, 16'h1235, 1'b1, 1'b1, 1'b1},
    {16'hFFFF, 16'h7FFF, 1'b0, 1'b1, 1'b0},
    {16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h8001, 16'h8001, 1'b1, 1'b0, 1'b0},
    {16'h0F0F, 16'hF0F0, 1'b1, 1'b1, 1'b1},
    {16'hCAFE, 16'hCAFE, 1'b1, 1'b0, 1'b0}
  };

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearFlag();
    statusRead = 1'b1; step(); statusRead = 1'b0;
  endtask

  task automatic sendWord(input logic [15:0] w);
    encWord = w; encStrobe = 1'b1; step(); encStrobe = 1'b0;
  endtask

  task automatic sendEcho(input logic [15:0] w);
    echoWord = w; echoStrobe = 1'b1; step(); echoStrobe = 1'b0;
  endtask

  task automatic pulseCmd();
    newCmd = 1'b1; step(); newCmd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    step(3);
    check("R10 wrapFail", wrapFail, 0);
    check("R10 wrapIrq", wrapIrq, 0);
    check("R10 trip", failsafeTrip, 0);
    check("R10 permit", txPermit, 3);
    rstN = 1'b1;
    step(2);

    // table walk: R1 R2 R3
    for (int i = 0; i < 7; i++) begin
      intEnable = VEC[i][2];
      sendWord(VEC[i][34:19]);
      step();
      sendEcho(VEC[i][18:3]);
      check($sformatf("R1/R2 vec%0d wrapFail", i), wrapFail, VEC[i][1]);
      check($sformatf("R3 vec%0d wrapIrq", i), wrapIrq, VEC[i][0]);
      step();
      check($sformatf("R3 vec%0d irq one cycle", i), wrapIrq, 0);
      check($sformatf("R4 vec%0d sticky", i), wrapFail, VEC[i][1]);
      clearFlag();
      check($sformatf("R4 vec%0d cleared", i), wrapFail, 0);
    end

    // R6: echo with nothing pending
    intEnable = 1'b1;
    sendEcho(16'hDEAD);
    check("R6 idle echo wrapFail", wrapFail, 0);
    check("R6 idle echo wrapIrq", wrapIrq, 0);

    // R5: late echo
    sendWord(16'h5555);
    step(15);
    check("R5 before wait window", wrapFail, 0);
    step(14);
    check("R5 late echo flagged", wrapFail, 1);
    clearFlag();
    sendEcho(16'h5555);
    check("R6 echo after timeout ignored", wrapFail, 0);

    // R5: overrun by second encoder word
    sendWord(16'h1111);
    step();
    sendWord(16'h2222);
    check("R5 overrun flagged", wrapFail, 1);
    clearFlag();
    sendEcho(16'h2222);
    check("R5 second word pending", wrapFail, 0);

    // R4: set and clear in the same cycle
    sendWord(16'h3333);
    echoWord = 16'h3330; echoStrobe = 1'b1; statusRead = 1'b1;
    step();
    echoStrobe = 1'b0; statusRead = 1'b0;
    check("R4 set wins over clear", wrapFail, 1);
    clearFlag();
    check("R4 read clears", wrapFail, 0);

    // R7 / R9: channel 0 runs over the ceiling, channel 1 idle
    pulseCmd();
    txActive = 2'b01;
    step(70);
    check("R7 not yet tripped", failsafeTrip[0], 0);
    check("R7 permit before trip", txPermit[0], 1);
    step(20);
    check("R7 tripped", failsafeTrip[0], 1);
    check("R7 permit low", txPermit[0], 0);
    check("R9 other channel independent", failsafeTrip[1], 0);
    txActive = 2'b00;
    step(5);
    check("R7 trip holds", failsafeTrip[0], 1);
    pulseCmd();
    check("R9 newCmd clears trip", failsafeTrip[0], 0);
    check("R9 permit restored", txPermit, 3);

    // R8: pause while inactive
    pulseCmd();
    txActive = 2'b10;
    step(40);
    txActive = 2'b00;
    step(200);
    check("R8 no count while idle", failsafeTrip[1], 0);
    txActive = 2'b10;
    step(30);
    check("R8 accumulated below ceiling", failsafeTrip[1], 0);
    step(20);
    check("R8 accumulated trip", failsafeTrip[1], 1);
    check("R8 permit low", txPermit[1], 0);
    txActive = 2'b00;
    pulseCmd();
    check("R9 clear channel1", failsafeTrip[1], 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule